// File: doc/BRIEF.md
# Program Counter with Latched Upper Bytes

This block holds a 21-bit byte-addressed program counter in which only the least significant byte is exposed as a data register. The two higher bytes cannot be written directly. Software places the values it wants in two holding latches, one for the middle byte and one for the top bits. A write to the low byte then loads the whole counter at once from the latches and the new low byte. A read of the low byte returns its value and also refreshes both latches from the live counter. With this, software can read the low byte, add a doubled table index to it, and write it back, so that execution jumps into a table of return-literal entries spaced two bytes apart.

During normal execution the counter advances by two bytes for each instruction, with carry into the higher bits. A low-byte write replaces that advance in the same cycle. The read data is registered and appears one clock after the read strobe.

Top module: `pc_latched_upper`

## Requirements
- R1: While reset is high, the counter, the read data and both holding latches go to zero. A low-byte write of value D made after reset, with no latch writes, loads the counter with D with bit 0 cleared.
- R2: A step strobe without a low-byte write adds 2 to the counter on the next clock. The carry passes into the middle and top bytes, and the counter wraps from 0x1FFFFE to 0x000000.
- R3: When neither the step strobe nor the low-byte write strobe is high, the counter keeps its value.
- R4: A low-byte write with data D loads the counter with {top latch[4:0], middle latch, D[7:1], 0} on the next clock.
- R5: Bit 0 of the counter is always zero.
- R6: When a low-byte write and a step strobe are high in the same cycle, the write takes effect and the step is dropped.
- R7: A low-byte read makes the read-data output equal to the counter's bits [7:0] from the read cycle, one clock later. Without a read strobe the read data keeps its value.
- R8: A low-byte read copies counter bits [20:16] into the top latch and bits [15:8] into the middle latch. A later low-byte write therefore keeps the upper part of the counter as it was when the read happened.
- R9: Direct writes to the middle or top latch do not change the counter. They take effect only at the next low-byte write.
- R10: When a low-byte read and a direct latch write happen in the same cycle, the copy from the counter wins over the direct write.
- R11: When a low-byte read and a low-byte write happen in the same cycle, the jump uses the latch contents from before that cycle, and the read data returns the low byte from before the jump. The latches then hold the pre-jump upper bytes.
- R12: Only bits [4:0] of a top-latch write are kept. Bits [7:5] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the counter by one instruction (2 bytes) |
| lo_rd_i | input | 1 | Low-byte read strobe; also refreshes both latches |
| lo_wr_i | input | 1 | Low-byte write strobe; loads the whole counter |
| lo_wdata_i | input | 8 | New low byte for a low-byte write |
| mid_latch_wr_i | input | 1 | Direct write of the middle holding latch |
| top_latch_wr_i | input | 1 | Direct write of the top holding latch |
| latch_wdata_i | input | 8 | Data for the direct latch writes |
| pc_o | output | 21 | Current program counter |
| lo_rdata_o | output | 8 | Registered low-byte read data |

## Verification
The holding latches have no output port. A wrong latch value stays hidden until the next low-byte write, and then it shows as wrong upper bits on `pc_o` one clock after that write. The bench therefore follows each latch scenario with a jump and checks the whole counter. A fault in the counter register or in the carry path shows on `pc_o` one clock after the step or write that caused it. A fault in the read path shows on `lo_rdata_o` one clock after the read strobe.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_LOAD = 2'd2
  } pc_op_e;

  function automatic int unsigned top_width(input int unsigned pc_w);
    return pc_w - 2 * BYTE_W;
  endfunction
endpackage

// File: rtl/pcl_op_decode.sv
module pcl_op_decode
  import pcl_pkg::*;
(
  input  logic   step_i,
  input  logic   lo_wr_i,
  output pc_op_e op_o
);
  // A low-byte write outranks sequential stepping.
  always_comb begin
    if (lo_wr_i)     op_o = PC_LOAD;
    else if (step_i) op_o = PC_STEP;
    else             op_o = PC_HOLD;
  end
endmodule

// File: rtl/pcl_latch_bank.sv
module pcl_latch_bank
  import pcl_pkg::*;
#(
  parameter int unsigned PC_W = 21,
  localparam int unsigned TOP_W = PC_W - 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              mid_wr_i,
  input  logic              top_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] mid_o,
  output logic [TOP_W-1:0]  top_o
);
  logic [BYTE_W-1:0] mid_q;
  logic [TOP_W-1:0]  top_q;

  // Refresh from the live counter has priority over direct software writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q <= '0;
      top_q <= '0;
    end else if (refresh_i) begin
      mid_q <= pc_i[2*BYTE_W-1:BYTE_W];
      top_q <= pc_i[PC_W-1:2*BYTE_W];
    end else begin
      if (mid_wr_i) mid_q <= wdata_i;
      if (top_wr_i) top_q <= wdata_i[TOP_W-1:0];
    end
  end

  assign mid_o = mid_q;
  assign top_o = top_q;
endmodule

// File: rtl/pcl_counter.sv
module pcl_counter
  import pcl_pkg::*;
#(
  parameter int unsigned PC_W = 21,
  parameter int unsigned STEP = 2,
  localparam int unsigned TOP_W = PC_W - 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_op_e            op_i,
  input  logic [BYTE_W-1:0] lo_data_i,
  input  logic [BYTE_W-1:0] mid_i,
  input  logic [TOP_W-1:0]  top_i,
  output logic [PC_W-1:0]   pc_o
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] jump_target;

  // Offsets are byte counts on two-byte instructions, so bit 0 is forced low.
  assign jump_target = {top_i, mid_i, lo_data_i[BYTE_W-1:1], 1'b0};

  always_comb begin
    case (op_i)
      PC_LOAD: pc_d = jump_target;
      PC_STEP: pc_d = pc_q + STEP_V;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcl_rd_port.sv
module pcl_rd_port
  import pcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= lo_i;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pc_latched_upper.sv
module pc_latched_upper
  import pcl_pkg::*;
#(
  parameter int unsigned PC_W = 21,
  parameter int unsigned STEP = 2,
  localparam int unsigned TOP_W = PC_W - 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              lo_rd_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] lo_wdata_i,
  input  logic              mid_latch_wr_i,
  input  logic              top_latch_wr_i,
  input  logic [BYTE_W-1:0] latch_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [BYTE_W-1:0] lo_rdata_o
);
  pc_op_e            op;
  logic [BYTE_W-1:0] mid_latch;
  logic [TOP_W-1:0]  top_latch;
  logic [PC_W-1:0]   pc_q;

  pcl_op_decode u_dec (
    .step_i  (step_i),
    .lo_wr_i (lo_wr_i),
    .op_o    (op)
  );

  pcl_latch_bank #(.PC_W(PC_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .refresh_i (lo_rd_i),
    .pc_i      (pc_q),
    .mid_wr_i  (mid_latch_wr_i),
    .top_wr_i  (top_latch_wr_i),
    .wdata_i   (latch_wdata_i),
    .mid_o     (mid_latch),
    .top_o     (top_latch)
  );

  pcl_counter #(.PC_W(PC_W), .STEP(STEP)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .lo_data_i (lo_wdata_i),
    .mid_i     (mid_latch),
    .top_i     (top_latch),
    .pc_o      (pc_q)
  );

  pcl_rd_port u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (lo_rd_i),
    .lo_i    (pc_q[BYTE_W-1:0]),
    .rdata_o (lo_rdata_o)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_latched_upper_chk.sv
module pc_latched_upper_chk #(
  parameter int unsigned PC_W = 21,
  parameter int unsigned STEP = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            step_i,
  input logic            lo_rd_i,
  input logic            lo_wr_i,
  input logic [7:0]      lo_wdata_i,
  input logic [PC_W-1:0] pc_o,
  input logic [7:0]      lo_rdata_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && lo_rdata_o == '0));

  // R2
  step_adds_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !lo_wr_i) |=> pc_o == PC_W'($past(pc_o) + PC_W'(STEP)));

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !lo_wr_i) |=> $stable(pc_o));

  // R4
  load_low_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr_i |=> pc_o[7:0] == {$past(lo_wdata_i[7:1]), 1'b0});

  // R5
  pc_even_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_o[0]);

  // R7
  read_data_chk: assert property (@(posedge clk) disable iff (rst)
    lo_rd_i |=> lo_rdata_o == $past(pc_o[7:0]));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_rd_i |=> $stable(lo_rdata_o));
endmodule

bind pc_latched_upper pc_latched_upper_chk #(.PC_W(PC_W), .STEP(STEP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_i     (step_i),
  .lo_rd_i    (lo_rd_i),
  .lo_wr_i    (lo_wr_i),
  .lo_wdata_i (lo_wdata_i),
  .pc_o       (pc_o),
  .lo_rdata_o (lo_rdata_o)
);

// File: tb/pc_latched_upper_bench.sv
module pc_latched_upper_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0, lo_rd_i = 1'b0, lo_wr_i = 1'b0;
  logic [7:0]  lo_wdata_i = '0;
  logic        mid_latch_wr_i = 1'b0, top_latch_wr_i = 1'b0;
  logic [7:0]  latch_wdata_i = '0;
  logic [20:0] pc_o;
  logic [7:0]  lo_rdata_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_latched_upper u_pc_latched_upper (
    .clk(clk), .rst(rst), .step_i(step_i), .lo_rd_i(lo_rd_i), .lo_wr_i(lo_wr_i),
    .lo_wdata_i(lo_wdata_i), .mid_latch_wr_i(mid_latch_wr_i),
    .top_latch_wr_i(top_latch_wr_i), .latch_wdata_i(latch_wdata_i),
    .pc_o(pc_o), .lo_rdata_o(lo_rdata_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; outputs are valid at the next falling edge.
  task automatic cyc(input logic st, input logic rd, input logic wr, input logic [7:0] wd,
                     input logic mw, input logic tw, input logic [7:0] ld);
    step_i = st; lo_rd_i = rd; lo_wr_i = wr; lo_wdata_i = wd;
    mid_latch_wr_i = mw; top_latch_wr_i = tw; latch_wdata_i = ld;
    @(negedge clk);
    step_i = 0; lo_rd_i = 0; lo_wr_i = 0; mid_latch_wr_i = 0; top_latch_wr_i = 0;
  endtask

  task automatic set_latches(input logic [7:0] top, input logic [7:0] mid);
    cyc(0, 0, 0, 8'h00, 1, 0, mid);
    cyc(0, 0, 0, 8'h00, 0, 1, top);
  endtask

  task automatic t_reset();
    check("R1 pc after reset", 32'(pc_o), 32'h0);
    check("R1 rdata after reset", 32'(lo_rdata_o), 32'h0);
    cyc(0, 0, 1, 8'h45, 0, 0, 8'h00);
    check("R1/R5 jump with zero latches", 32'(pc_o), 32'h000044);
  endtask

  task automatic t_step();
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00, 0, 0, 8'h00);
    check("R2 three steps", 32'(pc_o), 32'h00004A);
    set_latches(8'h03, 8'h12);
    check("R9 latch writes leave pc", 32'(pc_o), 32'h00004A);
    cyc(0, 0, 0, 8'h00, 0, 0, 8'h00);
    check("R3 idle hold", 32'(pc_o), 32'h00004A);
    cyc(0, 0, 1, 8'hFE, 0, 0, 8'h00);
    check("R4 jump from latches", 32'(pc_o), 32'h0312FE);
    cyc(1, 0, 0, 8'h00, 0, 0, 8'h00);
    check("R2 carry into middle byte", 32'(pc_o), 32'h031300);
    set_latches(8'h1F, 8'hFF);
    cyc(0, 0, 1, 8'hFF, 0, 0, 8'h00);
    check("R5 bit0 forced low", 32'(pc_o), 32'h1FFFFE);
    cyc(1, 0, 0, 8'h00, 0, 0, 8'h00);
    check("R2 wrap to zero", 32'(pc_o), 32'h000000);
    cyc(0, 0, 0, 8'h00, 0, 1, 8'hE5);
    cyc(0, 0, 1, 8'h10, 0, 0, 8'h00);
    check("R12 top latch bits 7:5 ignored", 32'(pc_o), 32'h05FF10);
  endtask

  task automatic t_read();
    set_latches(8'h00, 8'h00);
    cyc(0, 1, 0, 8'h00, 0, 0, 8'h00);
    check("R7 read data", 32'(lo_rdata_o), 32'h10);
    cyc(1, 0, 0, 8'h00, 0, 0, 8'h00);
    check("R7 rdata holds without read", 32'(lo_rdata_o), 32'h10);
    cyc(0, 0, 1, 8'h20, 0, 0, 8'h00);
    check("R8 read refreshed latches", 32'(pc_o), 32'h05FF20);
  endtask

  task automatic t_priority();
    cyc(1, 0, 1, 8'h30, 0, 0, 8'h00);
    check("R6 write beats step", 32'(pc_o), 32'h05FF30);
    cyc(0, 1, 0, 8'h00, 1, 1, 8'hAA);
    check("R9 pc unchanged by latch write", 32'(pc_o), 32'h05FF30);
    cyc(0, 0, 1, 8'h40, 0, 0, 8'h00);
    check("R10 refresh beats direct write", 32'(pc_o), 32'h05FF40);
    set_latches(8'h02, 8'h11);
    cyc(0, 1, 1, 8'h50, 0, 0, 8'h00);
    check("R11 jump uses old latches", 32'(pc_o), 32'h021150);
    check("R11 rdata is pre-jump byte", 32'(lo_rdata_o), 32'h40);
    cyc(0, 0, 1, 8'h60, 0, 0, 8'h00);
    check("R11 latches hold pre-jump bytes", 32'(pc_o), 32'h05FF60);
  endtask

  task automatic t_table();
    logic [7:0] base;
    cyc(0, 1, 0, 8'h00, 0, 0, 8'h00);
    base = lo_rdata_o;
    cyc(0, 0, 1, base + 8'd6, 0, 0, 8'h00);
    check("R4 computed table jump", 32'(pc_o), 32'h05FF66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_step();
    t_read();
    t_priority();
    t_table();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule